// File: doc/BRIEF.md
# SPI Switch-Input Monitor with Change Interrupt

This block watches a parallel bank of switch inputs and lets a host read them over a read-only SPI slave port. When the host pulls chip select low, the block takes a snapshot of all inputs into its shift register. The snapshot becomes the reference for change detection, and the same edge clears any pending interrupt, so every read also acknowledges the interrupt. The snapshot is shifted out most significant bit first. Bits arriving on the serial input are shifted in at the least significant end. After WIDTH clocks, the data of an upstream device therefore appears on the serial output, and several monitors can be chained.

An interrupt is raised as soon as any synchronized input differs from the reference snapshot. It stays raised until the next chip-select fall, even if the inputs return to their old values. An enable input gates the interrupt pin. While the enable is low, the pin is released, and the pending state is kept.

All pins are sampled by a fast system clock through two-flop synchronizers. The serial clock idles high. The serial input is sampled on each SCLK falling edge. Each SCLK rising edge advances the register. A host should sample the serial output on the falling edge. The pad drivers are outside this block. The serial output is given as a data bit plus an output enable; high-Z means that enable is low. The open-drain interrupt is given as a single "pull low" flag; when that flag is low, the pin is released.

Top module: `swmon_top`

## Requirements
- R1: While reset is held, sdout_oe is 0 and irq_drive_low is 0.
- R2: A falling edge on cs_n loads the present value of sw_in into the shift register. While cs_n is low, sdout_oe is 1 and sdout_data shows the register's most significant bit, so the snapshot's bit WIDTH-1 is the first bit out.
- R3: Each rising edge of sclk while cs_n is low moves the register one place toward the most significant end, so the snapshot leaves bit WIDTH-1 first and bit 0 last.
- R4: sdin is sampled on each falling edge of sclk and enters at bit 0 on the next rising edge. After WIDTH further clocks, the word sent on sdin (first bit first) is presented on sdout_data in the same order.
- R5: When cs_n is high, sdout_oe is 0.
- R6: When any synchronized input differs from the reference snapshot, the interrupt goes pending, and irq_drive_low becomes 1 while irq_en is 1. The interrupt stays pending if the inputs return to the snapshot value.
- R7: A falling edge on cs_n clears the pending interrupt and makes the captured value the new reference. An input change that reaches the synchronizer output in the same cycle as the chip-select fall is part of the snapshot and raises no interrupt. A change one cycle later is not part of the snapshot and raises the interrupt.
- R8: When irq_en is 0, irq_drive_low is 0 and the pin is released. Gating does not clear a pending interrupt, so setting irq_en back to 1 shows the interrupt again.
- R9: After reset, the reference holds the inputs present at reset release. With no input change, no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system oversampling clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, idles high |
| sdin | input | 1 | serial data in, for daisy-chaining |
| sdout_data | output | 1 | serial data out value |
| sdout_oe | output | 1 | serial data out enable (0 = high-Z) |
| sw_in | input | WIDTH | parallel switch inputs |
| irq_en | input | 1 | interrupt pin enable |
| irq_drive_low | output | 1 | 1 = pull interrupt pin low, 0 = release |

## Verification
Two things can land in the same system-clock cycle: the snapshot capture with its interrupt clear, and a change at the input synchronizer output. Both cs_n and sw_in pass through synchronizers of the same depth. The bench therefore changes sw_in on the same clock as it drops cs_n, and then one clock later. In the first case it expects the new value in the read-back word and no interrupt. In the second case it expects the old value and a pending interrupt. Randomized transfers check the read-back snapshot and the daisy-chained word, and they compare the interrupt with a bench model of the reference and the enable.

// File: rtl/swmon_pkg.sv
package swmon_pkg;

  typedef struct packed {
    logic selected;
    logic cs_fall;
    logic sclk_fall;
    logic sclk_rise;
  } spi_evt_t;

endpackage

// File: rtl/swmon_sync.sv
module swmon_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= g_stage[s-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/swmon_spi_edges.sv
module swmon_spi_edges
  import swmon_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_s,
  input  logic     sclk_s,
  output spi_evt_t evt
);

  logic cs_q;
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  always_comb begin
    evt.selected  = !cs_s;
    evt.cs_fall   = cs_q && !cs_s;
    evt.sclk_fall = sclk_q && !sclk_s && !cs_s;
    evt.sclk_rise = !sclk_q && sclk_s && !cs_s;
  end

  // a chip-select fall is never seen together with an unselected state
  p_fall_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cs_fall |=> !cs_q);

endmodule

// File: rtl/swmon_shifter.sv
module swmon_shifter
  import swmon_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  spi_evt_t     evt,
  input  logic [W-1:0] snap,
  input  logic         sdin_s,
  output logic         sdout_data,
  output logic         sdout_oe
);

  logic [W-1:0] shreg;
  logic         hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      hold  <= 1'b0;
    end else begin
      if (evt.cs_fall)        shreg <= snap;
      else if (evt.sclk_rise) shreg <= {shreg[W-2:0], hold};
      if (evt.sclk_fall)      hold  <= sdin_s;
    end
  end

  assign sdout_data = shreg[W-1];
  assign sdout_oe   = evt.selected;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cs_fall |=> sdout_data == $past(snap[W-1]));

  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.sclk_rise && !evt.cs_fall) |=> shreg[W-1:1] == $past(shreg[W-2:0]));

  p_insert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.sclk_rise && !evt.cs_fall) |=> shreg[0] == $past(hold));

endmodule

// File: rtl/swmon_change_irq.sv
module swmon_change_irq #(
  parameter int unsigned W = 16,
  parameter int unsigned PRIME = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_fall,
  input  logic [W-1:0] sw_s,
  input  logic         en_s,
  output logic         irq_drive_low
);

  localparam int unsigned CW = $clog2(PRIME + 1);

  logic [W-1:0]  ref_q;
  logic          pend;
  logic [CW-1:0] prime_cnt;
  logic          primed;
  logic          differs;

  assign primed  = (prime_cnt == CW'(PRIME));
  assign differs = (sw_s != ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q     <= '0;
      pend      <= 1'b0;
      prime_cnt <= '0;
    end else if (!primed) begin
      prime_cnt <= prime_cnt + 1'b1;
      ref_q     <= sw_s;
      pend      <= 1'b0;
    end else if (cs_fall) begin
      ref_q     <= sw_s;
      pend      <= 1'b0;
    end else if (differs) begin
      pend      <= 1'b1;
    end
  end

  assign irq_drive_low = pend && en_s;

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !pend);

  p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !cs_fall && differs) |=> pend);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !cs_fall && pend) |=> pend);

  p_quiet_prime_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !pend);

endmodule

// File: rtl/swmon_top.sv
module swmon_top
  import swmon_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdin,
  output logic             sdout_data,
  output logic             sdout_oe,
  input  logic [WIDTH-1:0] sw_in,
  input  logic             irq_en,
  output logic             irq_drive_low
);

  localparam int unsigned CTRL_W = 4;
  localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b1100;
  localparam int unsigned PRIME = SYNC_STAGES + 1;

  logic [CTRL_W-1:0] ctrl_s;
  logic [WIDTH-1:0]  sw_s;
  spi_evt_t          evt;

  swmon_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) i_ctrl_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdin, irq_en}), .q(ctrl_s)
  );

  swmon_sync #(.W(WIDTH), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sw_sync (
    .clk(clk), .rst_n(rst_n), .d(sw_in), .q(sw_s)
  );

  swmon_spi_edges i_edges (
    .clk(clk), .rst_n(rst_n), .cs_s(ctrl_s[3]), .sclk_s(ctrl_s[2]), .evt(evt)
  );

  swmon_shifter #(.W(WIDTH)) i_shift (
    .clk(clk), .rst_n(rst_n), .evt(evt), .snap(sw_s), .sdin_s(ctrl_s[1]),
    .sdout_data(sdout_data), .sdout_oe(sdout_oe)
  );

  swmon_change_irq #(.W(WIDTH), .PRIME(PRIME)) i_irq (
    .clk(clk), .rst_n(rst_n), .cs_fall(evt.cs_fall), .sw_s(sw_s),
    .en_s(ctrl_s[0]), .irq_drive_low(irq_drive_low)
  );

  p_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdout_oe);

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(irq_en, 1) && !$past(irq_en, 2) && !$past(irq_en, 3)) |-> !irq_drive_low);

endmodule

// File: tb/test_swmon_top.sv
module test_swmon_top;

  localparam int W = 16;
  localparam int HALF = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic sdin = 1'b0;
  logic [W-1:0] sw_in = 16'hA5C3;
  logic irq_en = 1'b1;
  logic sdout_data;
  logic sdout_oe;
  logic irq_drive_low;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int cycles = 0;

  always #2 clk = ~clk;

  swmon_top #(.WIDTH(W)) i_swmon_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .sdout_data(sdout_data), .sdout_oe(sdout_oe), .sw_in(sw_in),
    .irq_en(irq_en), .irq_drive_low(irq_drive_low)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_irq(input logic pending, input logic en);
    return pending && en;
  endfunction

  task automatic shift_bits(input logic [W-1:0] din, output logic [2*W-1:0] dout);
    for (int i = 0; i < 2 * W; i++) begin
      sdin = (i < W) ? din[W-1-i] : 1'b0;
      dout[2*W-1-i] = sdout_data;
      sclk = 1'b0;
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic deselect();
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2*W-1:0] rd;
    logic [W-1:0] snap_ref;
    logic [W-1:0] nv;
    logic [W-1:0] din;
    logic pending;
    int seed;
    seed = $urandom(32'h5eed);

    wait_clk(5);
    check(sdout_oe == 1'b0, "R1 oe in reset", 64'(sdout_oe), 0);
    check(irq_drive_low == 1'b0, "R1 irq in reset", 64'(irq_drive_low), 0);
    rst_n = 1'b1;
    wait_clk(12);
    check(irq_drive_low == 1'b0, "R9 no irq after reset", 64'(irq_drive_low), 0);
    check(sdout_oe == 1'b0, "R5 idle hiz", 64'(sdout_oe), 0);

    // first read: reset-time inputs, daisy word
    cs_n = 1'b0;
    wait_clk(6);
    check(sdout_oe == 1'b1, "R2 oe while selected", 64'(sdout_oe), 1);
    shift_bits(16'h3C96, rd);
    check(rd[2*W-1:W] == 16'hA5C3, "R3 snapshot msb first", 64'(rd[2*W-1:W]), 64'h A5C3);
    check(rd[W-1:0] == 16'h3C96, "R4 daisy pass-through", 64'(rd[W-1:0]), 64'h3C96);
    deselect();
    check(sdout_oe == 1'b0, "R5 hiz after deselect", 64'(sdout_oe), 0);
    snap_ref = 16'hA5C3;

    // raise, sticky, gate
    sw_in = 16'hA5C2;
    wait_clk(8);
    check(irq_drive_low == 1'b1, "R6 change raises", 64'(irq_drive_low), 1);
    sw_in = 16'hA5C3;
    wait_clk(8);
    check(irq_drive_low == 1'b1, "R6 sticky on return", 64'(irq_drive_low), 1);
    irq_en = 1'b0;
    wait_clk(8);
    check(irq_drive_low == 1'b0, "R8 gated off", 64'(irq_drive_low), 0);
    irq_en = 1'b1;
    wait_clk(8);
    check(irq_drive_low == 1'b1, "R8 pending kept", 64'(irq_drive_low), 1);
    cs_n = 1'b0;
    wait_clk(6);
    check(irq_drive_low == 1'b0, "R7 cs fall clears", 64'(irq_drive_low), 0);
    shift_bits(16'h0, rd);
    check(rd[2*W-1:W] == 16'hA5C3, "R2 snapshot", 64'(rd[2*W-1:W]), 64'hA5C3);
    deselect();

    // coincident change and capture
    sw_in = 16'h1234;
    cs_n = 1'b0;
    wait_clk(6);
    check(irq_drive_low == 1'b0, "R7 same-cycle change no irq", 64'(irq_drive_low), 0);
    shift_bits(16'h0, rd);
    check(rd[2*W-1:W] == 16'h1234, "R7 same-cycle change captured", 64'(rd[2*W-1:W]), 64'h1234);
    deselect();
    check(irq_drive_low == 1'b0, "R7 still quiet", 64'(irq_drive_low), 0);

    // change one cycle after capture
    cs_n = 1'b0;
    wait_clk(1);
    sw_in = 16'h4321;
    wait_clk(6);
    check(irq_drive_low == 1'b1, "R7 late change raises", 64'(irq_drive_low), 1);
    shift_bits(16'h0, rd);
    check(rd[2*W-1:W] == 16'h1234, "R7 late change not captured", 64'(rd[2*W-1:W]), 64'h1234);
    deselect();
    cs_n = 1'b0;
    wait_clk(6);
    shift_bits(16'h0, rd);
    deselect();
    snap_ref = 16'h4321;
    check(rd[2*W-1:W] == 16'h4321, "R2 recapture", 64'(rd[2*W-1:W]), 64'h4321);

    // randomized rounds
    for (int k = 0; k < 14; k++) begin
      nv = (($urandom % 4) == 0) ? snap_ref : W'($urandom);
      din = W'($urandom);
      sw_in = nv;
      wait_clk(8);
      pending = (nv != snap_ref);
      irq_en = 1'($urandom);
      wait_clk(8);
      check(irq_drive_low == exp_irq(pending, irq_en), "R6 R8 random irq",
            64'(irq_drive_low), 64'(exp_irq(pending, irq_en)));
      irq_en = 1'b1;
      cs_n = 1'b0;
      wait_clk(6);
      check(sdout_oe == 1'b1, "R2 random oe", 64'(sdout_oe), 1);
      shift_bits(din, rd);
      check(rd[2*W-1:W] == nv, "R3 random snapshot", 64'(rd[2*W-1:W]), 64'(nv));
      check(rd[W-1:0] == din, "R4 random daisy", 64'(rd[W-1:0]), 64'(din));
      deselect();
      check(irq_drive_low == 1'b0, "R7 random cleared", 64'(irq_drive_low), 0);
      check(sdout_oe == 1'b0, "R5 random hiz", 64'(sdout_oe), 0);
      snap_ref = nv;
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule